// File: doc/BRIEF.md
# I2C Sequential Read Slave with Nine-Bit Pointer

This block is the read side of an I2C slave that fronts a 272-location byte space (000h to 10Fh). A master first performs a dummy write: START, the slave address with R/W=0, and one address byte. It then issues a repeated START with R/W=1 and clocks out data bytes for as long as it acknowledges them. An eight-bit address byte reaches the nine-bit space because FFh maps to location 100h. The pointer steps by one per byte and wraps from 10Fh back to 000h.

SCL and SDA are oversampled in the system clock domain, and START and STOP are detected there. The block drives SDA through a pull-low enable and reads the array through a byte-wide port. That port carries a nine-bit location and a flag asking for the nonvolatile copy. Four control registers at 101h to 104h always return their nonvolatile copy when read.

Top module: `i2c_seqrd_slave`

## Requirements
- R1: The slave acknowledges a slave-address byte only when its upper seven bits equal {4'b1010, dev_lo_i}. On a mismatch it never drives SDA until the next START, and its pointer is left untouched.
- R2: After an acknowledged address with R/W=0, the next byte is acknowledged and loads the pointer. Address byte values 00h to FEh load the same location (upper pointer bit 0).
- R3: An address byte of FFh loads the pointer with 100h.
- R4: Data bytes are sent MSB first, and the slave starts pulling SDA low only while SCL is low.
- R5: The pointer advances by one after each transmitted data byte, and from 10Fh it goes to 000h.
- R6: The slave keeps sending bytes while the master acknowledges. After a master NACK it releases SDA for the rest of the transfer. A later read with R/W=1 and no address byte resumes at the advanced pointer.
- R7: mem_nv_o is high exactly while the pointer lies in 101h to 104h, so those four locations return their nonvolatile copy.
- R8: A START or STOP seen part-way through a byte abandons that byte. A partial address byte never loads the pointer, and a new transfer after it works normally.
- R9: After reset sda_oe_o is 0, mem_addr_o is 000h and mem_nv_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level (wired bus value) |
| dev_lo_i | input | 3 | Configurable low bits of the 7-bit slave address |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| mem_addr_o | output | 9 | Array location of the byte being fetched (pointer) |
| mem_nv_o | output | 1 | 1 requests the nonvolatile copy of the location |
| mem_data_i | input | 8 | Byte returned by the array for mem_addr_o |

## Verification
The bench goes after four corner cases. An address byte of FEh must stay at FEh while FFh must jump to 100h; a design with a plain zero extension would show FFh on mem_addr_o. A long read from 100h must pass 10Fh and continue at 000h, where a power-of-two wrap would reach 110h. A read after a NACK must resume one past the last byte sent, and a slave that kept driving after the NACK would corrupt the next byte clocked. A partial address byte cut short by a START or STOP must leave the pointer untouched, and a stale bit count would misalign every byte after it.

// File: rtl/i2c_seqrd_pkg.sv
package i2c_seqrd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADR,
    ST_ACKDRV,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_MOK,
    ST_HOLD
  } rd_state_t;

endpackage

// File: rtl/i2c_seqrd_bus.sv
module i2c_seqrd_bus #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_N-1:0] scl_pipe, sda_pipe;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_N-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_N-2:0], sda_i};
      scl_p    <= scl_pipe[SYNC_N-1];
      sda_p    <= sda_pipe[SYNC_N-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_N-1];
  assign sda_s     = sda_pipe[SYNC_N-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_seqrd_ptr.sv
module i2c_seqrd_ptr #(
  parameter int             PTR_W    = 9,
  parameter logic [PTR_W-1:0] LAST     = 9'h10F,
  parameter logic [PTR_W-1:0] JUMP     = 9'h100,
  parameter logic [PTR_W-1:0] NV_FIRST = 9'h101,
  parameter logic [PTR_W-1:0] NV_LAST  = 9'h104
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [7:0]       byte_i,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             nv_o
);

  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [PTR_W-1:0] ptr_q, nxt;
  logic             nv_q;

  always_comb begin
    nxt = ptr_q;
    if (load_i)
      nxt = (byte_i == 8'hFF) ? JUMP : {{(PTR_W-8){1'b0}}, byte_i};
    else if (adv_i)
      nxt = (ptr_q == LAST) ? '0 : ptr_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      nv_q  <= 1'b0;
    end else begin
      ptr_q <= nxt;
      nv_q  <= (nxt >= NV_FIRST) && (nxt <= NV_LAST);
    end
  end

  assign ptr_o = ptr_q;
  assign nv_o  = nv_q;

  // R5
  ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= LAST);

  // R5
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !load_i && ptr_q == LAST) |=> (ptr_q == '0));

  // R3
  ptr_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && byte_i == 8'hFF) |=> (ptr_q == JUMP));

  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && byte_i != 8'hFF) |=> (ptr_q[7:0] == $past(byte_i) && ptr_q[PTR_W-1:8] == '0));

endmodule

// File: rtl/i2c_seqrd_slave.sv
module i2c_seqrd_slave
  import i2c_seqrd_pkg::*;
#(
  parameter int               LO_W     = 3,
  parameter logic [6-LO_W:0]  DEV_HI   = 4'b1010,
  parameter int               PTR_W    = 9,
  parameter logic [PTR_W-1:0] LAST     = 9'h10F,
  parameter logic [PTR_W-1:0] JUMP     = 9'h100,
  parameter logic [PTR_W-1:0] NV_FIRST = 9'h101,
  parameter logic [PTR_W-1:0] NV_LAST  = 9'h104,
  parameter int               SYNC_N   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [LO_W-1:0]  dev_lo_i,
  output logic             sda_oe_o,
  output logic [PTR_W-1:0] mem_addr_o,
  output logic             mem_nv_o,
  input  logic [7:0]       mem_data_i
);

  localparam logic [3:0] LAST_BIT = 4'd7;
  localparam logic [3:0] BYTE_END = 4'd8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_seqrd_bus #(.SYNC_N(SYNC_N)) u_bus (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  rd_state_t  st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       rw_q, after_dev, oe_q, ld_q, adv_q;
  logic [7:0] in_byte;
  logic       dev_hit;

  assign in_byte = {sh[6:0], sda_s};
  assign dev_hit = (in_byte[7:1] == {DEV_HI, dev_lo_i});

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      rw_q      <= 1'b0;
      after_dev <= 1'b0;
      oe_q      <= 1'b0;
      ld_q      <= 1'b0;
      adv_q     <= 1'b0;
    end else begin
      ld_q  <= 1'b0;
      adv_q <= 1'b0;
      if (stop_det) begin
        st   <= ST_IDLE;
        oe_q <= 1'b0;
        cnt  <= '0;
      end else if (start_det) begin
        st   <= ST_DEV;
        oe_q <= 1'b0;
        cnt  <= '0;
      end else begin
        unique case (st)
          ST_DEV, ST_ADR: if (scl_rise) begin
            sh  <= in_byte;
            cnt <= cnt + 4'd1;
            if (cnt == LAST_BIT) begin
              cnt <= '0;
              if (st == ST_DEV) begin
                if (dev_hit) begin
                  rw_q      <= sda_s;
                  after_dev <= 1'b1;
                  st        <= ST_ACKDRV;
                end else begin
                  st <= ST_HOLD;
                end
              end else begin
                ld_q      <= 1'b1;
                after_dev <= 1'b0;
                st        <= ST_ACKDRV;
              end
            end
          end
          ST_ACKDRV: if (scl_fall) begin
            oe_q <= 1'b1;
            st   <= ST_ACK;
          end
          ST_ACK: if (scl_fall) begin
            oe_q <= 1'b0;
            cnt  <= '0;
            if (after_dev && rw_q) begin
              sh   <= mem_data_i;
              oe_q <= ~mem_data_i[7];
              st   <= ST_TX;
            end else if (after_dev) begin
              st <= ST_ADR;
            end else begin
              st <= ST_HOLD;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == BYTE_END) begin
                oe_q  <= 1'b0;
                adv_q <= 1'b1;
                st    <= ST_MACK;
              end else begin
                sh   <= {sh[6:0], 1'b0};
                oe_q <= ~sh[6];
              end
            end
          end
          ST_MACK: if (scl_rise) st <= sda_s ? ST_HOLD : ST_MOK;
          ST_MOK: if (scl_fall) begin
            sh   <= mem_data_i;
            oe_q <= ~mem_data_i[7];
            cnt  <= '0;
            st   <= ST_TX;
          end
          default: ;
        endcase
      end
    end
  end

  i2c_seqrd_ptr #(
    .PTR_W   (PTR_W),
    .LAST    (LAST),
    .JUMP    (JUMP),
    .NV_FIRST(NV_FIRST),
    .NV_LAST (NV_LAST)
  ) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .load_i(ld_q),
    .byte_i(sh),
    .adv_i (adv_q),
    .ptr_o (mem_addr_o),
    .nv_o  (mem_nv_o)
  );

  assign sda_oe_o = oe_q;

  // R4
  drive_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> !scl_s);

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !oe_q);

  // R8
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (!oe_q && cnt == '0));

  // R1
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD && !start_det) |=> !oe_q);

endmodule

// File: tb/test_i2c_seqrd_slave.sv
`timescale 1ns/1ps
module test_i2c_seqrd_slave;

  localparam int P = 4;
  localparam logic [6:0] DEV = 7'b1010_011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [8:0] mem_addr;
  logic mem_nv;
  logic [7:0] mem_data;
  wire  sda_line = sda_m & ~sda_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [7:0] model(input logic [8:0] a, input logic nv);
    logic [7:0] v;
    v = a[7:0] * 8'd7 + (a[8] ? 8'h3C : 8'h00);
    return nv ? (v ^ 8'hA5) : v;
  endfunction

  function automatic logic in_nv(input logic [8:0] a);
    return (a >= 9'h101) && (a <= 9'h104);
  endfunction

  function automatic logic [7:0] exp_byte(input logic [8:0] a);
    return model(a, in_nv(a));
  endfunction

  function automatic logic [8:0] step(input logic [8:0] a);
    return (a == 9'h10F) ? 9'h000 : a + 9'd1;
  endfunction

  assign mem_data = model(mem_addr, mem_nv);

  i2c_seqrd_slave i_i2c_seqrd_slave (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .dev_lo_i  (DEV[2:0]),
    .sda_oe_o  (sda_oe),
    .mem_addr_o(mem_addr),
    .mem_nv_o  (mem_nv),
    .mem_data_i(mem_data)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] expv, input string req);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; w(P);
    scl_m = 1'b1; w(P);
    sda_m = 1'b0; w(P);
    scl_m = 1'b0; w(P);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; w(P);
    scl_m = 1'b1; w(P);
    sda_m = 1'b1; w(P);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; w(2*P);
    scl_m = 1'b1; w(2*P);
    scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; w(2*P);
    scl_m = 1'b1; w(P);
    b = sda_line; w(P);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(ack);
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(nack);
  endtask

  task automatic set_ptr(input logic [7:0] a, input string req);
    logic ack;
    i2c_start();
    send_byte({DEV, 1'b0}, ack);
    check(16'(ack), 16'h0, req);
    send_byte(a, ack);
    check(16'(ack), 16'h0, req);
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    logic [8:0] p;
    w(5);
    rst = 1'b0;
    w(3);
    // R9 reset state
    check(16'(sda_oe), 16'h0, "R9");
    check(16'(mem_addr), 16'h0, "R9");
    check(16'(mem_nv), 16'h0, "R9");

    // R1 foreign address: no ACK, no drive, pointer untouched
    i2c_start();
    send_byte({7'b1010_010, 1'b1}, ack);
    check(16'(ack), 16'h1, "R1");
    recv_byte(d, 1'b1);
    check(16'(d), 16'hFF, "R1");
    i2c_stop();
    w(4);
    check(16'(mem_addr), 16'h0, "R1");

    // R2 R3 R7 every address byte loads the pointer
    for (int a = 0; a < 256; a++) begin
      set_ptr(8'(a), "R2");
      i2c_stop();
      w(4);
      p = (a == 255) ? 9'h100 : 9'(a);
      check(16'(mem_addr), 16'(p), (a == 255) ? "R3" : "R2");
      check(16'(mem_nv), 16'(in_nv(p)), "R7");
    end

    // R4 R5 random reads of two bytes from a spread of start points
    for (int a = 0; a < 256; a += 7) begin
      set_ptr(8'(a), "R4");
      i2c_start();
      send_byte({DEV, 1'b1}, ack);
      check(16'(ack), 16'h0, "R4");
      recv_byte(d, 1'b0);
      check(16'(d), 16'(exp_byte(9'(a))), "R4");
      recv_byte(d, 1'b1);
      check(16'(d), 16'(exp_byte(step(9'(a)))), "R5");
      i2c_stop();
    end

    // R5 R6 R7 long read from FFh through the wrap
    set_ptr(8'hFF, "R3");
    i2c_start();
    send_byte({DEV, 1'b1}, ack);
    p = 9'h100;
    for (int k = 0; k < 18; k++) begin
      recv_byte(d, (k == 17));
      check(16'(d), 16'(exp_byte(p)), (p >= 9'h101 && p <= 9'h104) ? "R7" : "R5");
      p = step(p);
    end
    // R6 released after NACK
    recv_byte(d, 1'b1);
    check(16'(d), 16'hFF, "R6");
    i2c_stop();
    w(4);
    check(16'(mem_addr), 16'h002, "R5");

    // R6 current-address read resumes at advanced pointer
    i2c_start();
    send_byte({DEV, 1'b1}, ack);
    check(16'(ack), 16'h0, "R6");
    recv_byte(d, 1'b1);
    check(16'(d), 16'(exp_byte(9'h002)), "R6");
    i2c_stop();

    // R8 START part-way through the slave-address byte
    i2c_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    set_ptr(8'h10, "R8");
    i2c_stop();
    w(4);
    check(16'(mem_addr), 16'h010, "R8");

    // R8 STOP part-way through the address byte leaves pointer alone
    i2c_start();
    send_byte({DEV, 1'b0}, ack);
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    i2c_stop();
    w(4);
    check(16'(mem_addr), 16'h010, "R8");
    check(16'(sda_oe), 16'h0, "R8");
    set_ptr(8'h42, "R8");
    i2c_start();
    send_byte({DEV, 1'b1}, ack);
    recv_byte(d, 1'b1);
    check(16'(d), 16'(exp_byte(9'h042)), "R8");
    i2c_stop();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule